// File: doc/BRIEF.md
# Line Transmit Pattern and Error Injector

This block sits in the transmit data path of a T1/E1 line interface, just before the bipolar line drivers. Each clock it chooses one bit to send. The choices are the user data, a forced all-ones stream, an alternating one/zero test pattern, or a pseudo-random test sequence whose length depends on the T1/E1 mode. The chosen bit is then AMI encoded onto two rails: a mark becomes a pulse on one rail, with the rail alternating from mark to mark, and a space leaves both rails low.

The transmitter sends all ones until a release input is set high. It also falls back to all ones on its own when the automatic option is enabled and the receiver reports a loss of carrier or an all-ones signal. For line testing, software can inject one inverted bit, or one bipolar violation. Each injection is requested by a rising edge on its control input. The violation is held back until the stream has three ones in a row.

Top module: `line_tx_pattern`

## Requirements
- R1: While `rst_n` is low, both rails are low. After reset, while `data_release` is 0 every transmitted bit is a mark, whatever the other inputs are.
- R2: With `auto_ones_en` at 1, every bit is a mark while `rx_carrier_loss` or `rx_all_ones` is 1. With `auto_ones_en` at 0, those two flags have no effect.
- R3: When the alternating pattern is the selected source, it sends 1,0,1,0,... Each time it becomes the selected source again, the pattern restarts with 1.
- R4: The pseudo-random source is a 20-bit register, loaded with all ones at reset. It advances only in cycles where it is the selected source. Each advance shifts the register one place toward the MSB and feeds bit 0 with s[14]^s[13] in E1 mode (`t1_mode`=0) or with s[19]^s[16] in T1 mode. The transmitted bit is s[14] in E1 mode and s[19] in T1 mode. In E1 mode the sequence repeats every 32767 bits.
- R5: Source priority, from highest to lowest: forced all ones (R1/R2), pseudo-random (`prbs_en`), alternating (`alt_en`), then user data `tx_data`.
- R6: In the cycle where `err_req` goes from 0 to 1, the bit chosen by R5 is inverted before encoding. Holding `err_req` high inverts nothing more. A new error needs `err_req` to go low and then high again.
- R7: A 0-to-1 transition on `bpv_req` arms one violation. Ones are counted from the arming cycle onward, and a zero restarts the count. The third consecutive one is sent with the same polarity as the previous mark.
- R8: After a violation has been sent, holding `bpv_req` high causes no further violation. Only a new 0-to-1 transition arms the next one.
- R9: The rails are never high together. The first mark after reset is positive. Every mark that is not a violation takes the polarity opposite to the previous mark, including the mark that follows a violation.
- R10: The rails are registered. A bit selected in one cycle appears on the rails after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_mode | input | 1 | 1 = T1 (20-stage sequence), 0 = E1 (15-stage sequence) |
| tx_data | input | 1 | User data bit |
| data_release | input | 1 | 0 forces all ones; 1 lets the selected source through |
| auto_ones_en | input | 1 | Enables all ones on receive alarms |
| alt_en | input | 1 | Selects the alternating pattern |
| prbs_en | input | 1 | Selects the pseudo-random sequence |
| bpv_req | input | 1 | Rising edge arms one bipolar violation |
| err_req | input | 1 | Rising edge inverts one bit |
| rx_carrier_loss | input | 1 | Receive carrier-loss flag |
| rx_all_ones | input | 1 | Receive all-ones flag |
| pos_out | output | 1 | Positive rail pulse |
| neg_out | output | 1 | Negative rail pulse |

## Verification
The bench builds the block with its default parameters: a 20-stage register, a 15-stage E1 sequence tapped at stage 14, and a 20-stage T1 sequence tapped at stage 17. With these values the whole E1 period of 32767 bits fits inside the run, so the bench checks that the sequence wraps on its exact length. The roughly one-million-bit T1 period does not fit, so the T1 check covers only its first bits, compared against a model of the feedback taken from R4.

// File: rtl/line_tx_pattern.sv
module line_tx_pattern #(
  parameter int E1_W   = 15,
  parameter int E1_TAP = 14,
  parameter int T1_W   = 20,
  parameter int T1_TAP = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t1_mode,
  input  logic tx_data,
  input  logic data_release,
  input  logic auto_ones_en,
  input  logic alt_en,
  input  logic prbs_en,
  input  logic bpv_req,
  input  logic err_req,
  input  logic rx_carrier_loss,
  input  logic rx_all_ones,
  output logic pos_out,
  output logic neg_out
);
  localparam int LW = (T1_W > E1_W) ? T1_W : E1_W;

  logic [LW-1:0] lfsr;
  logic          alt_ph;
  logic          err_prev;
  logic          bpv_prev;
  logic          armed;
  logic [1:0]    run;
  logic          last_pol;
  logic          sel_bit;

  wire force_ones = !data_release | (auto_ones_en & (rx_carrier_loss | rx_all_ones));
  wire prbs_sel   = !force_ones & prbs_en;
  wire alt_sel    = !force_ones & !prbs_en & alt_en;

  wire prbs_bit = t1_mode ? lfsr[T1_W-1] : lfsr[E1_W-1];
  wire prbs_fb  = t1_mode ? (lfsr[T1_W-1] ^ lfsr[T1_TAP-1])
                          : (lfsr[E1_W-1] ^ lfsr[E1_TAP-1]);
  wire e1_dead  = (lfsr[E1_W-1:0] == '0);

  always_comb begin
    if (force_ones)   sel_bit = 1'b1;
    else if (prbs_en) sel_bit = prbs_bit;
    else if (alt_en)  sel_bit = alt_ph;
    else              sel_bit = tx_data;
  end

  wire err_rise = err_req & !err_prev;
  wire tx_bit   = sel_bit ^ err_rise;

  wire arm_eff  = armed | (bpv_req & !bpv_prev);
  wire bpv_inj  = arm_eff & tx_bit & (run == 2'd2);
  wire pol      = bpv_inj ? last_pol : !last_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr     <= '1;
      alt_ph   <= 1'b1;
      err_prev <= 1'b0;
      bpv_prev <= 1'b0;
      armed    <= 1'b0;
      run      <= 2'd0;
      last_pol <= 1'b0;
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
    end else begin
      err_prev <= err_req;
      bpv_prev <= bpv_req;
      if (prbs_sel)
        lfsr <= (!t1_mode && e1_dead) ? '1 : {lfsr[LW-2:0], prbs_fb};
      alt_ph <= alt_sel ? !alt_ph : 1'b1;
      armed  <= arm_eff & !bpv_inj;
      if (!arm_eff || !tx_bit || bpv_inj) run <= 2'd0;
      else                                run <= run + 2'd1;
      if (tx_bit) last_pol <= pol;
      pos_out <= tx_bit & pol;
      neg_out <= tx_bit & !pol;
    end
  end
endmodule

module line_tx_pattern_chk (
  input logic clk,
  input logic rst_n,
  input logic pos_out,
  input logic neg_out,
  input logic force_ones,
  input logic alt_sel,
  input logic err_rise,
  input logic sel_bit,
  input logic tx_bit,
  input logic bpv_inj
);
  logic seen_pos;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_pos <= 1'b0;
    else if (pos_out || neg_out) seen_pos <= pos_out;
  end

  // R9
  rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

  // R9
  ami_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (pos_out || neg_out) && !$past(bpv_inj)) |-> (pos_out == !seen_pos));

  // R7
  bpv_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bpv_inj)) |-> ((pos_out || neg_out) && (pos_out == seen_pos)));

  // R7
  bpv_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && bpv_inj) |-> (tx_bit && $past(tx_bit) && $past(tx_bit, 2)));

  // R1
  forced_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ones && !err_rise) |=> (pos_out || neg_out));

  // R6
  err_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise |=> ((pos_out || neg_out) != $past(sel_bit)));

  // R3
  alt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && alt_sel && !err_rise && $past(alt_sel && !err_rise))
      |=> ((pos_out || neg_out) != $past(pos_out || neg_out)));
endmodule

bind line_tx_pattern line_tx_pattern_chk u_chk (.*);

// File: tb/tb_line_tx_pattern.sv
`timescale 1ns/1ps
module tb_line_tx_pattern;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t1_mode = 1'b0, tx_data = 1'b0, data_release = 1'b0, auto_ones_en = 1'b0;
  logic alt_en = 1'b0, prbs_en = 1'b0, bpv_req = 1'b0, err_req = 1'b0;
  logic rx_carrier_loss = 1'b0, rx_all_ones = 1'b0;
  logic pos_out, neg_out;

  int total = 0;
  int bad = 0;
  logic last_seen = 1'b0;
  logic last_mark = 1'b0;
  logic [19:0] m = '1;
  logic [19:0] first_bits;

  always #2.5 clk = !clk;

  line_tx_pattern dut (
    .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .tx_data(tx_data),
    .data_release(data_release), .auto_ones_en(auto_ones_en), .alt_en(alt_en),
    .prbs_en(prbs_en), .bpv_req(bpv_req), .err_req(err_req),
    .rx_carrier_loss(rx_carrier_loss), .rx_all_ones(rx_all_ones),
    .pos_out(pos_out), .neg_out(neg_out)
  );

  // {release, auto, carrier_loss, all_ones_rx, data, expected mark}
  localparam logic [5:0] VEC [12] = '{
    6'b000001, 6'b100000, 6'b100011, 6'b111001,
    6'b110101, 6'b110000, 6'b101100, 6'b111111,
    6'b010001, 6'b100011, 6'b110011, 6'b101000
  };

  task automatic tick(input int expm, input bit viol, input string tag);
    logic mark, exp_pos;
    @(posedge clk);
    @(negedge clk);
    mark = pos_out | neg_out;
    if (expm >= 0) begin
      total++;
      exp_pos = viol ? last_seen : !last_seen;
      if ((mark != expm[0]) || (mark && (pos_out != exp_pos)) || (pos_out && neg_out)) begin
        bad++;
        $display("FAIL %s: pos=%0b neg=%0b, expected mark=%0d pos=%0b", tag,
                 pos_out, neg_out, expm, exp_pos);
      end
    end
    last_mark = mark;
    if (mark) last_seen = pos_out;
  endtask

  task automatic prbs_tick(input string tag);
    logic b, fb;
    b  = t1_mode ? m[19] : m[14];
    fb = t1_mode ? (m[19] ^ m[16]) : (m[14] ^ m[13]);
    tick(int'(b), 1'b0, tag);
    m = {m[18:0], fb};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) tick(0, 1'b0, "R1 rails low in reset");
    rst_n = 1'b1;
    last_seen = 1'b0;
    m = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 4; i++) tick(1, 1'b0, "R1 all ones before release, R9 first mark positive");

    for (int i = 0; i < 12; i++) begin
      {data_release, auto_ones_en, rx_carrier_loss, rx_all_ones, tx_data} = VEC[i][5:1];
      tick(int'(VEC[i][0]), 1'b0, "R1/R2 table vector");
    end

    data_release = 1'b1; auto_ones_en = 1'b0; rx_carrier_loss = 1'b0;
    rx_all_ones = 1'b0; tx_data = 1'b0; alt_en = 1'b1;
    for (int i = 0; i < 6; i++) tick((i % 2 == 0) ? 1 : 0, 1'b0, "R3 alternating");
    data_release = 1'b0;
    tick(1, 1'b0, "R5 forced ones over alternating");
    data_release = 1'b1;
    tick(1, 1'b0, "R3 restart at one");
    tick(0, 1'b0, "R3 restart second bit");

    prbs_en = 1'b1;
    for (int i = 0; i < 40; i++) prbs_tick("R4/R5 E1 sequence over alternating");
    data_release = 1'b0;
    tick(1, 1'b0, "R5 forced ones over sequence");
    tick(1, 1'b0, "R5 forced ones over sequence");
    data_release = 1'b1;
    for (int i = 0; i < 10; i++) prbs_tick("R4 sequence holds while not selected");

    do_reset();
    for (int i = 0; i < 20; i++) begin
      tick(-1, 1'b0, "R4");
      first_bits[i] = last_mark;
    end
    for (int i = 20; i < 32767; i++) tick(-1, 1'b0, "R4");
    for (int i = 0; i < 20; i++) tick(int'(first_bits[i]), 1'b0, "R4 E1 period 32767");

    t1_mode = 1'b1;
    do_reset();
    for (int i = 0; i < 30; i++) prbs_tick("R4 T1 sequence");

    prbs_en = 1'b0; alt_en = 1'b0; tx_data = 1'b0;
    tick(0, 1'b0, "R5 user data zero");
    err_req = 1'b1;
    tick(1, 1'b0, "R6 single error on rise");
    tick(0, 1'b0, "R6 no error while held");
    tick(0, 1'b0, "R6 no error while held");
    err_req = 1'b0;
    tick(0, 1'b0, "R6 no error on fall");
    err_req = 1'b1;
    tick(1, 1'b0, "R6 second rise");
    err_req = 1'b0; data_release = 1'b0;
    tick(1, 1'b0, "R1 forced ones");
    err_req = 1'b1;
    tick(0, 1'b0, "R6 error applied after selection");
    tick(1, 1'b0, "R6 forced ones resume");
    err_req = 1'b0; data_release = 1'b1;

    tx_data = 1'b0; bpv_req = 1'b1;
    tick(0, 1'b0, "R7 arming cycle space");
    tx_data = 1'b1; tick(1, 1'b0, "R7 run one");
    tick(1, 1'b0, "R7 run two");
    tx_data = 1'b0; tick(0, 1'b0, "R7 run broken");
    tx_data = 1'b1; tick(1, 1'b0, "R7 new run one");
    tick(1, 1'b0, "R7 new run two");
    tick(1, 1'b1, "R7 violation on third one");
    tick(1, 1'b0, "R9 alternation after violation");
    for (int i = 0; i < 5; i++) tick(1, 1'b0, "R8 held request no violation");
    tx_data = 1'b0; bpv_req = 1'b0;
    tick(0, 1'b0, "R8 request cleared");
    tx_data = 1'b1; bpv_req = 1'b1;
    tick(1, 1'b0, "R7 arming cycle counts as first one");
    tick(1, 1'b0, "R7 second one");
    tick(1, 1'b1, "R8 rearmed violation");
    tick(1, 1'b0, "R10 R9 normal mark after");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule